// File: doc/BRIEF.md
# Frame Receive Buffer Manager

The block takes received frames one byte per cycle from a MAC-side indication stream and stores them in an 8 KB receive memory. The memory is split into eight fixed 1 KB slots, so at most eight frames wait for the host at any time. The first six bytes of each frame are its destination address. These bytes are checked against a programmable 48-bit station address and against the all-ones broadcast address. A frame that matches neither is dropped while it is still arriving. Its slot is not consumed, so the next frame lands in the same slot.

A kept frame's payload starts at byte offset 4 of its slot. When the last byte arrives, a 32-bit status record is written into word 0 of the same slot and the slot is flagged full. The record holds the stored length, the match flags, an error flag and a transmit-status byte. The host reads the memory one 32-bit word at a time. It frees slots by presenting a slot index on a release strobe. Slots fill and drain in arrival order. Frames that arrive while every slot is occupied are dropped and counted.

Top module: `rx_frame_bufmgr`

## Requirements
- R1: After reset, `slot_full` is all zeros, `ovf_count` is zero and `discard` is low.
- R2: Byte k of a kept frame is stored at slot byte offset k+4. The host address is {slot index, word index}, so that byte sits in word (k+4)/4, lane (k+4)%4, with lane 0 in bits 7:0. `host_rdata` returns the word addressed on the previous clock edge.
- R3: Word 0 of a committed slot holds the status record: bits 15:0 stored length, bit 16 station match, bit 17 broadcast match, bit 18 error, bits 23:19 zero, bits 31:24 transmit status.
- R4: Frame bytes 0..5 are compared with `station_addr[47:40]` down to `station_addr[7:0]`, and also with 8'hFF. If neither comparison holds over all six bytes, `discard` is high from the cycle after byte 5. The frame is then not stored, no slot is marked, and the following frame reuses the same slot.
- R5: A frame whose last byte arrives before byte 5 is discarded without marking any slot.
- R6: Committed frames take slots 0,1,...,7 in order and wrap back to 0. Each commit sets exactly one `slot_full` bit, on the end-byte edge.
- R7: A frame that starts while all slots are full is dropped. `discard` is high from the cycle after its first byte and `ovf_count` increments by one, saturating at its maximum.
- R8: Only the first 1020 bytes of a longer frame are stored. Its length field reads 1020 and its error bit is set.
- R9: `in_bad` high on a frame's last byte sets the error bit of its status.
- R10: A release frees a slot only when `rel_slot` names the oldest full slot. Any other index leaves `slot_full` unchanged.
- R11: `tx_stat` as sampled with the end byte appears in status bits 31:24.
- R12: A frame commit and an accepted release on the same edge both take effect.
- R13: `in_first` during an unfinished frame abandons that frame, and the new frame goes into the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte valid |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_bad | input | 1 | Frame error, taken with the last byte |
| in_byte | input | 8 | Received byte |
| station_addr | input | 48 | Station address, first byte in bits 47:40 |
| tx_stat | input | 8 | Transmit status byte stored with each frame |
| host_addr | input | 11 | Host read word address {slot, word} |
| host_rdata | output | 32 | Host read data, one cycle after address |
| rel_valid | input | 1 | Slot release strobe |
| rel_slot | input | 3 | Slot index to release |
| slot_full | output | 8 | Per-slot full flags |
| ovf_count | output | 8 | Frames dropped for lack of a slot |
| discard | output | 1 | Current frame is being dropped |

## Verification
The host release and the commit of an arriving frame can land on the same edge, and both update the slot flags. The bench fills all eight slots and frees slot 0. It then sends a frame whose end byte is driven in the same cycle as a release of slot 1. The check is that the slot flags show slot 0 set and slot 1 cleared, and that the frame and its status read back intact. Filter rejection and overflow are judged by the exact cycle at which `discard` is first seen high.

// File: rtl/rx_frame_bufmgr.sv
module rx_frame_bufmgr #(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 1024,
  parameter int OVF_W      = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  input  logic                                    in_first,
  input  logic                                    in_last,
  input  logic                                    in_bad,
  input  logic [7:0]                              in_byte,
  input  logic [47:0]                             station_addr,
  input  logic [7:0]                              tx_stat,
  input  logic [$clog2(SLOTS*SLOT_BYTES/4)-1:0]   host_addr,
  output logic [31:0]                             host_rdata,
  input  logic                                    rel_valid,
  input  logic [$clog2(SLOTS)-1:0]                rel_slot,
  output logic [SLOTS-1:0]                        slot_full,
  output logic [OVF_W-1:0]                        ovf_count,
  output logic                                    discard
);
  localparam int SW  = $clog2(SLOTS);
  localparam int WPS = SLOT_BYTES / 4;
  localparam int OW  = $clog2(WPS);
  localparam int CW  = $clog2(SLOT_BYTES) + 1;
  localparam logic [CW-1:0] MAXP = CW'(SLOT_BYTES - 4);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic          sta_ok, bc_ok, trunc;
  logic [SW-1:0] wr_slot, rd_slot;
  logic [31:0]   mem [SLOTS*WPS];

  logic [CW-1:0]  n, boff, len_now;
  logic [2:0]     ai;
  logic [7:0]     sa_byte;
  logic           in_da, sta_now, bc_now, hit, take, store, commit, kill, trunc_now, rel_ok;
  logic [31:0]    stat_word;
  logic [SLOTS-1:0] full_nxt;

  assign n         = in_first ? '0 : cnt;
  assign in_da     = n < CW'(6);
  assign ai        = in_da ? n[2:0] : 3'd0;
  assign sa_byte   = station_addr[8*(5-int'(ai)) +: 8];
  assign sta_now   = (in_first | sta_ok) & (!in_da | (in_byte == sa_byte));
  assign bc_now    = (in_first | bc_ok) & (!in_da | (in_byte == 8'hFF));
  assign hit       = sta_now | bc_now;
  assign take      = in_valid && (in_first ? !slot_full[wr_slot] : (st == S_RECV));
  assign store     = take && (n < MAXP);
  assign boff      = n + CW'(4);
  assign len_now   = store ? n + CW'(1) : MAXP;
  assign trunc_now = (!in_first & trunc) | (n >= MAXP);
  assign commit    = take && in_last && (n >= CW'(5)) && hit;
  assign kill      = take && !in_last && (n == CW'(5)) && !hit;
  assign stat_word = {tx_stat, 5'd0, trunc_now | in_bad, bc_now, sta_now, 16'(len_now)};
  assign rel_ok    = rel_valid && (rel_slot == rd_slot) && slot_full[rd_slot];
  assign discard   = (st == S_DROP);

  always_comb begin
    full_nxt = slot_full;
    if (commit) full_nxt[wr_slot] = 1'b1;
    if (rel_ok) full_nxt[rd_slot] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sta_ok    <= 1'b0;
      bc_ok     <= 1'b0;
      trunc     <= 1'b0;
      wr_slot   <= '0;
      rd_slot   <= '0;
      slot_full <= '0;
      ovf_count <= '0;
    end else begin
      slot_full <= full_nxt;
      if (rel_ok) rd_slot <= rd_slot + 1'b1;
      if (in_valid) begin
        if (in_first && slot_full[wr_slot]) begin
          if (ovf_count != '1) ovf_count <= ovf_count + 1'b1;
          st <= in_last ? S_IDLE : S_DROP;
        end else if (take) begin
          cnt    <= len_now;
          sta_ok <= sta_now;
          bc_ok  <= bc_now;
          trunc  <= trunc_now;
          st     <= in_last ? S_IDLE : (kill ? S_DROP : S_RECV);
          if (commit) wr_slot <= wr_slot + 1'b1;
        end else if (in_last) begin
          st <= S_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store)  mem[{wr_slot, boff[OW+1:2]}][8*boff[1:0] +: 8] <= in_byte;
    if (commit) mem[{wr_slot, OW'(0)}] <= stat_word;
    host_rdata <= mem[host_addr];
  end
endmodule

// File: rtl/rx_frame_bufmgr_chk.sv
module rx_frame_bufmgr_chk #(
  parameter int SLOTS = 8,
  parameter int OVF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_first,
  input logic             in_last,
  input logic             rel_valid,
  input logic [SLOTS-1:0] slot_full,
  input logic [OVF_W-1:0] ovf_count,
  input logic             discard
);
  // R7
  ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |->
      ($past(in_valid && in_first && (&slot_full)) && (ovf_count == $past(ovf_count) + 1'b1)));

  // R7
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && !in_last && (&slot_full)) |=> discard);

  // R10
  clear_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rel_valid) |-> ((~slot_full & $past(slot_full)) == '0));

  // R6
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_full & ~$past(slot_full)) <= 1);

  // R6
  commit_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_full & ~$past(slot_full)) != '0) |-> $past(in_valid && in_last));

  // R4
  discard_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discard) |-> $past(in_valid));
endmodule

bind rx_frame_bufmgr rx_frame_bufmgr_chk #(.SLOTS(SLOTS), .OVF_W(OVF_W)) chk_i (.*);

// File: tb/rx_frame_bufmgr_tb_top.sv
`timescale 1ns/1ps
module rx_frame_bufmgr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_bad = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic [7:0]  tx_stat = '0;
  logic [10:0] host_addr = '0;
  logic [31:0] host_rdata;
  logic        rel_valid = 1'b0;
  logic [2:0]  rel_slot = '0;
  logic [7:0]  slot_full;
  logic [7:0]  ovf_count;
  logic        discard;

  int checks = 0, failures = 0, first_disc;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_frame_bufmgr dut_i (.*);

  function automatic logic [7:0] fb(int i, int seed, int kind);
    logic [7:0] sb;
    if (i < 6) begin
      sb = station_addr[8*(5-i) +: 8];
      if (kind == 1) return 8'hFF;
      if (kind == 2 && i == 3) return sb ^ 8'h80;
      return sb;
    end
    return 8'(i * 13 + seed);
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic send_frame(int len, int kind, bit bad, logic [7:0] txs, int seed,
                            bit no_end, bit rel_end, logic [2:0] ridx);
    first_disc = -1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (first_disc < 0 && discard) first_disc = i;
      in_valid = 1'b1;
      in_first = (i == 0);
      in_last  = (i == len-1) && !no_end;
      in_bad   = bad && in_last;
      in_byte  = fb(i, seed, kind);
      tx_stat  = txs;
      rel_valid = rel_end && in_last;
      rel_slot  = ridx;
    end
    @(negedge clk);
    if (first_disc < 0 && discard) first_disc = len;
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_bad = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic chk_frame(int slot, int len, int kind, bit err, logic [7:0] txs, int seed, string req);
    logic [31:0] d, e;
    int stored, last, w, lane;
    stored = (len > 1020) ? 1020 : len;
    e = {txs, 5'd0, err, kind == 1, kind == 0, 16'(stored)};
    rd({3'(slot), 8'd0}, d);
    check(d == e, req, "status word", d, e);
    e = {fb(3, seed, kind), fb(2, seed, kind), fb(1, seed, kind), fb(0, seed, kind)};
    rd({3'(slot), 8'd1}, d);
    check(d == e, req, "first data word", d, e);
    last = stored - 1; w = (last + 4) / 4; lane = (last + 4) % 4;
    rd({3'(slot), 8'(w)}, d);
    check(d[8*lane +: 8] == fb(last, seed, kind), req, "last stored byte", d[8*lane +: 8], fb(last, seed, kind));
  endtask

  task automatic do_release(logic [2:0] idx);
    @(negedge clk); rel_valid = 1'b1; rel_slot = idx;
    @(negedge clk); rel_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(slot_full == 8'h00, "R1", "slot_full", slot_full, 0);
    check(ovf_count == 8'h00, "R1", "ovf_count", ovf_count, 0);
    check(discard == 1'b0, "R1", "discard", discard, 0);
  endtask

  task automatic t_unicast;
    send_frame(64, 0, 0, 8'hA5, 1, 0, 0, 0);
    check(slot_full == 8'h01, "R6", "slot_full after first frame", slot_full, 8'h01);
    chk_frame(0, 64, 0, 0, 8'hA5, 1, "R2 R3 R11");
  endtask

  task automatic t_bcast;
    send_frame(6, 1, 0, 8'h3C, 2, 0, 0, 0);
    check(slot_full == 8'h03, "R4", "broadcast kept", slot_full, 8'h03);
    chk_frame(1, 6, 1, 0, 8'h3C, 2, "R4 broadcast");
  endtask

  task automatic t_mismatch;
    send_frame(40, 2, 0, 8'h11, 7, 0, 0, 0);
    check(first_disc == 6, "R4", "discard first cycle", 64'(first_disc), 6);
    check(slot_full == 8'h03, "R4", "slot_full after reject", slot_full, 8'h03);
    send_frame(20, 0, 0, 8'h22, 3, 0, 0, 0);
    chk_frame(2, 20, 0, 0, 8'h22, 3, "R4 rollback");
  endtask

  task automatic t_short;
    send_frame(4, 0, 0, 8'h00, 4, 0, 0, 0);
    check(slot_full == 8'h07, "R5", "short frame not kept", slot_full, 8'h07);
  endtask

  task automatic t_err;
    send_frame(30, 0, 1, 8'h5A, 8, 0, 0, 0);
    chk_frame(3, 30, 0, 1, 8'h5A, 8, "R9 R5");
  endtask

  task automatic t_long;
    send_frame(1030, 0, 0, 8'h77, 10, 0, 0, 0);
    chk_frame(4, 1030, 0, 1, 8'h77, 10, "R8");
  endtask

  task automatic t_restart;
    send_frame(10, 0, 0, 8'h01, 5, 1, 0, 0);
    check(slot_full == 8'h1F, "R13", "abandoned frame not kept", slot_full, 8'h1F);
    send_frame(20, 0, 0, 8'h02, 6, 0, 0, 0);
    check(slot_full == 8'h3F, "R13", "restart frame slot", slot_full, 8'h3F);
    chk_frame(5, 20, 0, 0, 8'h02, 6, "R13");
  endtask

  task automatic t_fill;
    send_frame(8, 0, 0, 8'h66, 11, 0, 0, 0);
    send_frame(9, 1, 0, 8'h67, 12, 0, 0, 0);
    check(slot_full == 8'hFF, "R6", "all slots full", slot_full, 8'hFF);
    chk_frame(7, 9, 1, 0, 8'h67, 12, "R6");
  endtask

  task automatic t_overflow;
    send_frame(16, 0, 0, 8'h00, 13, 0, 0, 0);
    check(first_disc == 1, "R7", "overflow discard cycle", 64'(first_disc), 1);
    check(ovf_count == 8'd1, "R7", "ovf_count", ovf_count, 1);
    check(slot_full == 8'hFF, "R7", "slots untouched", slot_full, 8'hFF);
    send_frame(7, 1, 0, 8'h00, 14, 0, 0, 0);
    check(ovf_count == 8'd2, "R7", "ovf_count second", ovf_count, 2);
    chk_frame(0, 64, 0, 0, 8'hA5, 1, "R7 slot0 intact");
  endtask

  task automatic t_release;
    do_release(3'd3);
    check(slot_full == 8'hFF, "R10", "out-of-order release ignored", slot_full, 8'hFF);
    do_release(3'd0);
    check(slot_full == 8'hFE, "R10", "oldest slot released", slot_full, 8'hFE);
  endtask

  task automatic t_simul;
    send_frame(12, 0, 0, 8'h9C, 9, 0, 1, 3'd1);
    check(slot_full == 8'hFD, "R12", "commit and release together", slot_full, 8'hFD);
    chk_frame(0, 12, 0, 0, 8'h9C, 9, "R12 R6 wrap");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_unicast;
    t_bcast;
    t_mismatch;
    t_short;
    t_err;
    t_long;
    t_restart;
    t_fill;
    t_overflow;
    t_release;
    t_simul;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule